// File: doc/BRIEF.md
# Bus Controller Data Buffer

This block sits behind the data register of a serial bus controller. Software writes outgoing bytes into a small transmit shift store and reads incoming bytes out of a receive queue. The transfer sequencer takes transmit bytes from one stream and returns received bytes on another. The block decides whether each register access is accepted. It then emits one-cycle pulses that set or clear the controller's status bits. The status register and the interrupt logic live elsewhere.

A register write carries a width flag. A byte-wide write may only target the data address. It shifts the held bytes up by one position and puts the new byte in the lowest position. A 16-bit write shifts in two bytes at once. The sequencer always receives the oldest held byte first.

Both byte streams use valid/ready handshakes. On the transmit stream, `tx_valid` stays high while any byte is held. The sequencer may hold `tx_ready` low for as long as it likes, and the byte presented does not change meanwhile. On the receive stream, `rx_ready` falls when the queue is full, and a byte offered then stays with the sequencer until space frees up. Every pulse output is registered and is high for the single cycle that follows the clock edge on which the access was sampled.

Top module: `dbuf_top`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1, `reg_rd_data` is 0 and every pulse output is 0.
- R2: A byte write (`reg_wr_byte`=1) to `DATA_ADDR` is accepted when at most 2 bytes are held. It adds one byte, and bytes leave on the transmit stream oldest first.
- R3: A byte write to `DATA_ADDR` while more than 2 bytes are held is dropped. The held bytes do not change and no status pulse is raised.
- R4: An accepted write of either width pulses `xudf_clr`. It also pulses `xrdy_clr` when the count after the write, not counting a same-cycle pop, is above 2.
- R5: A 16-bit write to `DATA_ADDR` adds bits [15:8] first and then bits [7:0], two bytes in all. It is accepted only if the count stays within `TX_CAP`; otherwise it is dropped with no pulse.
- R6: A byte write to any address other than `DATA_ADDR` changes nothing and pulses `acc_err`.
- R7: `tx_valid` is high exactly while bytes are held. While `tx_ready` is low, `tx_data` stays stable.
- R8: `rx_ready` is high while fewer than `RX_CAP` bytes are queued. A byte offered while the queue is full is not taken.
- R9: A read of `DATA_ADDR` returns the oldest queued byte in bits [7:0], with zeros above, in the next cycle, and removes that byte.
- R10: A read of `DATA_ADDR` from an empty queue returns 0, leaves the queue unchanged and raises neither `rrdy_clr` nor `ardy_set`.
- R11: A read that removes the last queued byte, with no byte arriving in the same cycle, pulses `rrdy_clr`. It also pulses `ardy_set` if `mst_mode`=1 and `trx_mode`=0.
- R12: Every read or write to `DATA_ADDR`, whether accepted or dropped, pulses `seq_kick` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address of the access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_byte | input | 1 | 1 = byte-wide write, 0 = 16-bit write |
| reg_wr_data | input | 16 | Write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_data | output | 16 | Read data, registered |
| mst_mode | input | 1 | Controller is in master mode |
| trx_mode | input | 1 | Controller is transmitting |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Sequencer takes the transmit byte |
| tx_data | output | 8 | Oldest held transmit byte |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_ready | output | 1 | Receive queue has space |
| rx_data | input | 8 | Received byte |
| xudf_clr | output | 1 | Pulse: clear transmit-underflow status |
| xrdy_clr | output | 1 | Pulse: clear transmit-ready status |
| rrdy_clr | output | 1 | Pulse: clear receive-ready status |
| ardy_set | output | 1 | Pulse: set access-ready status |
| acc_err | output | 1 | Pulse: byte-wide access to a wrong address |
| seq_kick | output | 1 | Pulse: sequencer may continue |

## Verification
On every cycle the assertions check the following:
- a dropped byte write leaves the transmit count alone;
- the transmit byte holds steady under back-pressure;
- the receive count never exceeds its capacity;
- an empty read yields zero;
- `ardy_set` appears only after master receive mode;
- `seq_kick` follows every data access.

The byte order across mixed-width writes, the exact cycles of the status pulses, and the refusal of writes at each fill level can only be shown by the bench's scenarios.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [1:0] {
    WR_NONE,
    WR_BYTE,
    WR_WORD,
    WR_BAD
  } wr_kind_e;
endpackage

// File: rtl/dbuf_tx_shift.sv
module dbuf_tx_shift #(
  parameter int TX_CAP = 4,
  localparam int TCW = $clog2(TX_CAP + 1),
  localparam int SW  = TX_CAP * 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_byte,
  input  logic           req_word,
  input  logic [15:0]    din,
  input  logic           pop,
  output logic           byte_ok,
  output logic           word_ok,
  output logic [TCW-1:0] cnt,
  output logic [7:0]     head
);
  logic [SW-1:0] store;

  assign byte_ok = req_byte && (int'(cnt) <= 2);
  assign word_ok = req_word && (int'(cnt) + 2 <= TX_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store <= '0;
      cnt   <= '0;
    end else begin
      if (byte_ok)
        store <= {store[SW-9:0], din[7:0]};
      else if (word_ok)
        store <= {store[SW-17:0], din};
      cnt <= cnt + TCW'(byte_ok) + (word_ok ? TCW'(2) : TCW'(0)) - TCW'(pop);
    end
  end

  always_comb begin
    head = '0;
    for (int i = 0; i < TX_CAP; i++)
      if (cnt == TCW'(i + 1)) head = store[i*8 +: 8];
  end

  // R3
  byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_byte && int'(cnt) > 2 && !pop) |=> (cnt == $past(cnt)));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 0 && !pop && !req_byte && !req_word) |=> (head == $past(head)));
endmodule

// File: rtl/dbuf_rx_fifo.sv
module dbuf_rx_fifo #(
  parameter int RX_CAP = 2,
  localparam int RCW = $clog2(RX_CAP + 1),
  localparam int FW  = RX_CAP * 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_byte,
  input  logic           rd_req,
  output logic           rd_pop,
  output logic           push_acc,
  output logic [7:0]     head,
  output logic [RCW-1:0] cnt
);
  logic [FW-1:0]  flat, flat_nx;
  logic [RCW-1:0] wr_idx;

  assign in_ready = int'(cnt) < RX_CAP;
  assign push_acc = in_valid && in_ready;
  assign rd_pop   = rd_req && (cnt != 0);
  assign head     = flat[7:0];
  assign wr_idx   = cnt - RCW'(rd_pop);

  always_comb begin
    flat_nx = rd_pop ? (flat >> 8) : flat;
    for (int i = 0; i < RX_CAP; i++)
      if (push_acc && wr_idx == RCW'(i)) flat_nx[i*8 +: 8] = in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flat <= '0;
      cnt  <= '0;
    end else begin
      flat <= flat_nx;
      cnt  <= cnt + RCW'(push_acc) - RCW'(rd_pop);
    end
  end

  // R8
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= RX_CAP);
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags #(
  parameter int TCW = 3,
  parameter int RCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_ok,
  input  logic           word_ok,
  input  logic [TCW-1:0] tx_cnt,
  input  logic           bad_byte,
  input  logic           data_access,
  input  logic           rd_pop,
  input  logic           rx_push,
  input  logic [RCW-1:0] rx_cnt,
  input  logic           mst_mode,
  input  logic           trx_mode,
  output logic           xudf_clr,
  output logic           xrdy_clr,
  output logic           rrdy_clr,
  output logic           ardy_set,
  output logic           acc_err,
  output logic           seq_kick
);
  logic accepted, over_two, emptied;

  assign accepted = byte_ok || word_ok;
  assign over_two = (byte_ok && int'(tx_cnt) + 1 > 2) ||
                    (word_ok && int'(tx_cnt) + 2 > 2);
  assign emptied  = rd_pop && (rx_cnt == RCW'(1)) && !rx_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xudf_clr <= 1'b0;
      xrdy_clr <= 1'b0;
      rrdy_clr <= 1'b0;
      ardy_set <= 1'b0;
      acc_err  <= 1'b0;
      seq_kick <= 1'b0;
    end else begin
      xudf_clr <= accepted;
      xrdy_clr <= over_two;
      rrdy_clr <= emptied;
      ardy_set <= emptied && mst_mode && !trx_mode;
      acc_err  <= bad_byte;
      seq_kick <= data_access;
    end
  end
endmodule

// File: rtl/dbuf_top.sv
module dbuf_top #(
  parameter int              ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h1c,
  parameter int              TX_CAP    = 4,
  parameter int              RX_CAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic              reg_wr_byte,
  input  logic [15:0]       reg_wr_data,
  input  logic              reg_rd_en,
  output logic [15:0]       reg_rd_data,
  input  logic              mst_mode,
  input  logic              trx_mode,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              xudf_clr,
  output logic              xrdy_clr,
  output logic              rrdy_clr,
  output logic              ardy_set,
  output logic              acc_err,
  output logic              seq_kick
);
  import dbuf_pkg::*;

  localparam int TCW = $clog2(TX_CAP + 1);
  localparam int RCW = $clog2(RX_CAP + 1);

  wr_kind_e       wr_kind;
  logic           at_data, rd_hit, data_access;
  logic           byte_ok, word_ok, tx_pop, rd_pop, rx_push;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic [7:0]     rx_head;

  assign at_data = (reg_addr == DATA_ADDR);
  assign rd_hit  = reg_rd_en && at_data;

  always_comb begin
    wr_kind = WR_NONE;
    if (reg_wr_en) begin
      if (reg_wr_byte) wr_kind = at_data ? WR_BYTE : WR_BAD;
      else if (at_data) wr_kind = WR_WORD;
    end
  end

  assign data_access = rd_hit || (reg_wr_en && at_data);
  assign tx_valid    = (tx_cnt != 0);
  assign tx_pop      = tx_valid && tx_ready;

  dbuf_tx_shift #(.TX_CAP(TX_CAP)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .req_byte(wr_kind == WR_BYTE), .req_word(wr_kind == WR_WORD),
    .din(reg_wr_data), .pop(tx_pop),
    .byte_ok(byte_ok), .word_ok(word_ok),
    .cnt(tx_cnt), .head(tx_data)
  );

  dbuf_rx_fifo #(.RX_CAP(RX_CAP)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_byte(rx_data),
    .rd_req(rd_hit), .rd_pop(rd_pop), .push_acc(rx_push),
    .head(rx_head), .cnt(rx_cnt)
  );

  dbuf_flags #(.TCW(TCW), .RCW(RCW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .byte_ok(byte_ok), .word_ok(word_ok), .tx_cnt(tx_cnt),
    .bad_byte(wr_kind == WR_BAD), .data_access(data_access),
    .rd_pop(rd_pop), .rx_push(rx_push), .rx_cnt(rx_cnt),
    .mst_mode(mst_mode), .trx_mode(trx_mode),
    .xudf_clr(xudf_clr), .xrdy_clr(xrdy_clr), .rrdy_clr(rrdy_clr),
    .ardy_set(ardy_set), .acc_err(acc_err), .seq_kick(seq_kick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rd_data <= '0;
    else if (rd_hit)
      reg_rd_data <= rd_pop ? {8'h00, rx_head} : 16'h0000;
  end

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rx_cnt == 0) |=> (reg_rd_data == 16'h0000 && !rrdy_clr && !ardy_set));

  // R11
  ardy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_set |-> ($past(mst_mode) && !$past(trx_mode) && rrdy_clr));

  // R12
  kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_access |=> seq_kick);

  // R6
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_byte && !at_data && !tx_pop) |=> (acc_err && tx_cnt == $past(tx_cnt)));
endmodule

// File: tb/dbuf_top_test.sv
module dbuf_top_test;
  localparam logic [5:0] DA = 6'h1c;
  localparam logic [5:0] OTHER = 6'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr_en = 0, reg_wr_byte = 0, reg_rd_en = 0;
  logic [15:0] reg_wr_data = '0, reg_rd_data;
  logic mst_mode = 0, trx_mode = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [7:0] tx_data, rx_data = '0;
  logic xudf_clr, xrdy_clr, rrdy_clr, ardy_set, acc_err, seq_kick;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbuf_top uut (.*);

  // byte flag, at data addr, data, exp xudf, xrdy, err, kick, pad
  localparam int NV = 6;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b1, 1'b1, 16'h00A1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
    {1'b1, 1'b1, 16'h00B2, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
    {1'b1, 1'b1, 16'h00C3, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00},
    {1'b1, 1'b1, 16'h00D4, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00},
    {1'b1, 1'b0, 16'h00EE, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},
    {1'b0, 1'b1, 16'h1122, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic bw, logic [5:0] a, logic [15:0] d);
    reg_wr_en = 1; reg_wr_byte = bw; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic pop_check(string req, logic [7:0] exp);
    check(req, {15'd0, tx_valid}, 16'd1);
    check(req, {8'd0, tx_data}, {8'd0, exp});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic rx_push(logic [7:0] b);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic do_read(string req, logic [15:0] exp, logic exp_rrdy, logic exp_ardy);
    reg_rd_en = 1; reg_addr = DA;
    @(negedge clk);
    reg_rd_en = 0;
    check(req, reg_rd_data, exp);
    check(req, {15'd0, rrdy_clr}, {15'd0, exp_rrdy});
    check(req, {15'd0, ardy_set}, {15'd0, exp_ardy});
    check("R12", {15'd0, seq_kick}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", {15'd0, tx_valid}, 16'd0);
    check("R1", {15'd0, rx_ready}, 16'd1);
    check("R1", reg_rd_data, 16'd0);
    check("R1", {10'd0, xudf_clr, xrdy_clr, rrdy_clr, ardy_set, acc_err, seq_kick}, 16'd0);

    // R2 R3 R4 R5 R6 R12 table
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][23], VEC[i][22] ? DA : OTHER, VEC[i][21:6]);
      check("R4", {15'd0, xudf_clr}, {15'd0, VEC[i][5]});
      check("R4", {15'd0, xrdy_clr}, {15'd0, VEC[i][4]});
      check("R6", {15'd0, acc_err}, {15'd0, VEC[i][3]});
      check("R12", {15'd0, seq_kick}, {15'd0, VEC[i][2]});
    end

    // R7 stall: byte stays put
    check("R7", {8'd0, tx_data}, 16'h00A1);
    @(negedge clk);
    check("R7", {8'd0, tx_data}, 16'h00A1);
    // R2 R3 R6 drain order, dropped bytes absent
    pop_check("R2", 8'hA1);
    pop_check("R2", 8'hB2);
    pop_check("R3", 8'hC3);
    check("R7", {15'd0, tx_valid}, 16'd0);

    // R5 word writes
    do_write(0, DA, 16'h3344);
    check("R5", {14'd0, xudf_clr, xrdy_clr}, 16'b10);
    do_write(0, DA, 16'h5566);
    check("R5", {14'd0, xudf_clr, xrdy_clr}, 16'b11);
    do_write(1, DA, 16'h0099);
    check("R3", {14'd0, xudf_clr, xrdy_clr}, 16'b00);
    pop_check("R5", 8'h33);
    pop_check("R5", 8'h44);
    pop_check("R5", 8'h55);
    pop_check("R5", 8'h66);
    check("R3", {15'd0, tx_valid}, 16'd0);

    // R8 receive queue
    mst_mode = 1; trx_mode = 0;
    rx_push(8'h5A);
    rx_push(8'h6B);
    check("R8", {15'd0, rx_ready}, 16'd0);
    rx_push(8'h7E);
    // R9 R11
    do_read("R9", 16'h005A, 0, 0);
    do_read("R11", 16'h006B, 1, 1);
    // R10
    do_read("R10", 16'h0000, 0, 0);
    check("R8", {15'd0, rx_ready}, 16'd1);
    trx_mode = 1;
    rx_push(8'h77);
    do_read("R11", 16'h0077, 1, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule